// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block supervises a single activity strobe driven by a processor. The strobe must change level at least once per timeout window. A rising edge and a falling edge both restart the window. If the strobe stays at one level for the whole window, the active-low timeout flag falls. It stays low until a new strobe edge or a system reset clears the count.

The strobe is asynchronous to the block clock. It passes through a flop synchronizer before edge detection, so a pulse only needs to last long enough to be sampled. The system reset holds the count at zero, so the window opens only when reset is released. A supply-good input overrides the flag: while the supply is low the flag is held low. When the supply recovers the override lifts at once, and the flag then shows the real watchdog state. The supply input has no effect on the counter. Feeding the flag back into a reset source is left to the surrounding logic.

Top module: `edge_watchdog`

## Requirements
- R1: While rst_ni is low, the counter is zero and timeout_no is 1 (with supply_ok_i = 1). After rst_ni is released with the strobe unchanged, timeout_no falls on exactly the TIMEOUT_CYCLES-th rising clock edge after release.
- R2: A strobe level change clears the count on the third rising clock edge after the change: two synchronizer flops plus the counter register. timeout_no then falls on the TIMEOUT_CYCLES-th rising edge after that clear, and stays 1 before it.
- R3: A low-to-high strobe change restarts the count. If the flag was low, it returns to 1 on the third rising edge after the change.
- R4: A high-to-low strobe change restarts the count in the same way as a rising change.
- R5: Once timed out, timeout_no stays 0 for as long as the strobe stays still. The counter saturates at TIMEOUT_CYCLES and never wraps.
- R6: A strobe pulse one clock cycle wide counts as activity. Its two edges clear the count on the third and fourth rising edges after it starts.
- R7: While supply_ok_i is 0, timeout_no is 0 at once, whether or not a timeout has occurred.
- R8: When supply_ok_i returns to 1, the override lifts with no clock delay. The count continues as if the supply had never dropped.
- R9: A strobe edge that reaches the counter in the cycle the count would reach TIMEOUT_CYCLES wins: no timeout is flagged.
- R10: Asserting rst_ni in the middle of a count forces timeout_no to 1 at once and restarts the full window from release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous system reset; holds the count clear |
| strobe_i | input | 1 | Activity strobe from the processor, asynchronous |
| supply_ok_i | input | 1 | 1 = supply above threshold, 0 = undervoltage |
| timeout_no | output | 1 | Active-low timeout flag, forced low on undervoltage |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 20 and SYNC_STAGES = 2. A timeout window is then short enough to cover many times in a short run. The 5-bit counter this gives would wrap at 32, so holding past three windows shows that saturation works. The short window also lets the bench line a strobe edge up with the exact terminal cycle. It also lets the bench drop and restore the supply partway through a window, and assert reset in the middle of a count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_SYNC_MIN = 2;

  function automatic int unsigned wdt_cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
  parameter int unsigned STAGES = wdt_pkg::WDT_SYNC_MIN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  // either polarity counts as activity
  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = wdt_pkg::wdt_cnt_width(LIMIT);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == LIMIT_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;   // edge wins over terminal count
    else if (!at_limit) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = at_limit;

  // R2
  clear_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  // R5
  saturate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_q == LIMIT_V) |=> cnt_q == LIMIT_V);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT_V);
  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_q != LIMIT_V) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic supply_ok_i,
  output logic timeout_no
);
  logic strobe_edge;
  logic expired;

  wdt_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (strobe_i),
    .edge_o (strobe_edge)
  );

  wdt_counter #(.LIMIT(TIMEOUT_CYCLES)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (strobe_edge),
    .expired_o (expired)
  );

  // undervoltage override, released without hold-off
  assign timeout_no = supply_ok_i & ~expired;

  // R3 R8
  flag_release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_no) |-> ($past(strobe_edge) || !$past(supply_ok_i)));
  // R9
  edge_beats_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_edge |=> !expired);
endmodule

// File: tb/test_edge_watchdog.sv
`timescale 1ns/1ps
module test_edge_watchdog;
  localparam int unsigned LIM = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe = 1'b0;
  logic supply_ok = 1'b1;
  logic timeout_no;

  int unsigned cyc = 0;
  int unsigned n_run = 0;
  int unsigned n_fail = 0;

  typedef struct {
    int unsigned at;
    logic        val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  edge_watchdog #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(2)) i_edge_watchdog (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .supply_ok_i (supply_ok),
    .timeout_no  (timeout_no)
  );

  task automatic expect_at(int unsigned dly, logic val, string tag);
    sb_q.push_back('{cyc + dly, val, tag});
  endtask

  task automatic check_now(logic val, string tag);
    n_run++;
    if (timeout_no !== val) begin
      n_fail++;
      $display("FAIL %s: timeout_no=%b expected %b at cycle %0d", tag, timeout_no, val, cyc);
    end
  endtask

  task automatic wait_cyc(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares the flag with queued expectations after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t item;
      item = sb_q.pop_front();
      n_run++;
      if (item.at != cyc || timeout_no !== item.val) begin
        n_fail++;
        $display("FAIL %s: timeout_no=%b expected %b at cycle %0d (due %0d)",
                 item.tag, timeout_no, item.val, cyc, item.at);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    #1 check_now(1'b1, "R1 in reset");
    // R1: window opens at release
    rst_ni = 1'b1;
    expect_at(LIM - 1, 1'b1, "R1");
    expect_at(LIM, 1'b0, "R1");
    // R5: saturation well past a 5-bit wrap
    expect_at(3 * LIM, 1'b0, "R5");
    wait_cyc(3 * LIM + 2);

    // R3: rising change clears
    strobe = 1'b1;
    expect_at(2, 1'b0, "R3");
    expect_at(3, 1'b1, "R3");
    expect_at(LIM + 2, 1'b1, "R2");
    expect_at(LIM + 3, 1'b0, "R2");
    wait_cyc(LIM + 6);

    // R4: falling change clears
    strobe = 1'b0;
    expect_at(3, 1'b1, "R4");
    expect_at(LIM + 2, 1'b1, "R4");
    expect_at(LIM + 3, 1'b0, "R4");
    wait_cyc(LIM + 6);

    // R9: second edge arrives on the terminal cycle
    strobe = 1'b1;
    wait_cyc(LIM);
    strobe = 1'b0;
    expect_at(2, 1'b1, "R9");
    expect_at(3, 1'b1, "R9");
    expect_at(LIM + 2, 1'b1, "R9");
    expect_at(LIM + 3, 1'b0, "R9");
    wait_cyc(LIM + 6);

    // R6: one-cycle pulse
    strobe = 1'b1;
    expect_at(2, 1'b0, "R6");
    expect_at(3, 1'b1, "R6");
    expect_at(LIM + 3, 1'b1, "R6");
    expect_at(LIM + 4, 1'b0, "R6");
    wait_cyc(1);
    strobe = 1'b0;
    wait_cyc(LIM + 6);

    // R7 R8: supply dip mid-window leaves the count alone
    strobe = 1'b1;
    expect_at(LIM + 2, 1'b1, "R8");
    expect_at(LIM + 3, 1'b0, "R8");
    wait_cyc(5);
    supply_ok = 1'b0;
    #1 check_now(1'b0, "R7");
    wait_cyc(3);
    #1 check_now(1'b0, "R7");
    supply_ok = 1'b1;
    #1 check_now(1'b1, "R8");
    wait_cyc(LIM);
    // supply return while timed out: flag stays low
    supply_ok = 1'b0;
    #1 check_now(1'b0, "R7");
    supply_ok = 1'b1;
    #1 check_now(1'b0, "R8");
    wait_cyc(2);

    // R10: reset mid-count
    strobe = 1'b0;
    wait_cyc(10);
    rst_ni = 1'b0;
    #1 check_now(1'b1, "R10");
    wait_cyc(3);
    #1 check_now(1'b1, "R10");
    rst_ni = 1'b1;
    expect_at(LIM - 1, 1'b1, "R10");
    expect_at(LIM, 1'b0, "R10");
    wait_cyc(LIM + 3);

    wait (sb_q.size() == 0);
    wait_cyc(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule